// File: doc/BRIEF.md
# Nibble-Sliced Precision-Scalable Sample Memory

This block holds the complex samples of a memory-based FFT engine. Each sample word is kept as 4-bit slices in a grid of banks. There are five slice rows, one for each nibble position from bits 19:16 down to bits 3:0. There are four operand columns, one for each input of a radix-4 butterfly. One address selects the four operands of one butterfly. Each bank is a quarter of the FFT length deep.

The engine selects a run-time word-length of 8, 12, 16 or 20 bits and then moves data in bursts. A burst starts with a read or write strobe. It then visits one slice row per cycle, starting at the most significant row. Each beat carries the same nibble of all four operands over a 16-bit bus. A short word-length touches only the upper rows, so a burst lasts two to five cycles. A decoder driven by the word-length holds the unused lower rows powered down. Data in a powered-down row is lost.

Top module: `nibble_sample_mem`

## Requirements
- R1: After reset, `rvalid`, `done` and `rdata` are 0, the active word-length is 20 bits and `row_pwr_en` is 5'b11111.
- R2: `wl_sel` codes 0, 1, 2 and 3 select 8, 12, 16 and 20 bits. A burst at these lengths has exactly 2, 3, 4 and 5 beats, and produces the same number of `rvalid` cycles for a read.
- R3: Beat k of a burst accesses slice row 4-k, so the first beat carries bits 19:16. On the bus, operand A is in bits 3:0, B in 7:4, C in 11:8 and D in 15:12.
- R4: A write burst begins in the cycle where `wr_req` is seen while idle, which is beat 0. `wdata` is captured on every beat into the current row of the address given in that cycle. A later read of the same address at the same word-length returns the stored nibbles.
- R5: A read burst begins in the cycle where `rd_req` is seen while idle. The row read on each beat appears on `rdata`, with `rvalid` high, in the following cycle.
- R6: `done` is high for exactly one cycle. That cycle is the one after the last beat of a burst.
- R7: Strobes that arrive while a burst is running are ignored and do not change memory. If `rd_req` and `wr_req` are both high when a burst is accepted, the burst is a write.
- R8: A change of `wl_sel` during a burst changes neither the beat count nor `row_pwr_en`. The new value takes effect in the first idle cycle after the burst.
- R9: `row_pwr_en[r]` enables slice row r. Only the top `wl_sel`+2 rows are enabled (5'b11000, 5'b11100, 5'b11110, 5'b11111).
- R10: A row loses its contents while powered down. After it is enabled again, reads from it return zero until it is written again.
- R11: `rdata` is zero in every cycle where `rvalid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wl_sel | input | 2 | Word-length code: 0=8, 1=12, 2=16, 3=20 bits |
| addr | input | 4 | Butterfly address, sampled at burst start |
| rd_req | input | 1 | Read burst strobe |
| wr_req | input | 1 | Write burst strobe |
| wdata | input | 16 | Write beat {D,C,B,A} nibbles |
| rdata | output | 16 | Read beat {D,C,B,A} nibbles |
| rvalid | output | 1 | `rdata` holds a read beat |
| done | output | 1 | One-cycle pulse after the final beat |
| row_pwr_en | output | 5 | Per-row power enables, bit r for row r |

## Verification
Suppose the beat counter or the latched burst length is corrupted. The result shows at the ports within one burst: `done` lands one cycle early or late, or `rvalid` runs for the wrong number of cycles. Suppose instead the row pointer or the bus packing is wrong. Then the nibbles land in the wrong place, but that shows only on the read-back of the written address, so each write is followed at once by a read. A lost or unexpectedly kept valid bit shows only after a power-down and power-up cycle, so the bench writes full words, drops to 8 bits, returns to 20 bits and reads back.

// File: rtl/nsm_pkg.sv
// Package: shared geometry of the nibble-sliced sample memory.
// Assumes five slice rows of four bits and four butterfly operand columns.
package nsm_pkg;
    localparam int NIB_W  = 4;
    localparam int ROWS   = 5;
    localparam int COLS   = 4;
    localparam int BUS_W  = NIB_W * COLS;
    localparam int ROW_W  = $clog2(ROWS);
    localparam int MIN_ROWS = 2;

    typedef logic [1:0] wl_code_t;
endpackage

// File: rtl/nsm_pwr_dec.sv
// Module: nsm_pwr_dec
// Turns the active word-length code into per-row power enables.
// Row r is enabled when it is one of the top (code + MIN_ROWS) rows.
// Assumes ROWS - MIN_ROWS + 1 word-length codes.
module nsm_pwr_dec
    import nsm_pkg::*;
(
    input  wl_code_t          wl_code,
    output logic [ROWS-1:0]   row_en
);
    // One comparator per row: enabled when the row is within the active range
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign row_en[r] = ((r + int'(wl_code)) >= (ROWS - MIN_ROWS));
    end
endmodule

// File: rtl/nsm_bank.sv
// Module: nsm_bank
// One nibble-wide bank with a live bit per word.
// Powering the bank down clears every live bit, which models the loss of
// content. A word that is not live reads as zero. Writes apply only while
// the bank is powered. Reading is combinational from the address.
module nsm_bank #(
    parameter int DEPTH = 16,
    parameter int AW    = $clog2(DEPTH),
    parameter int W     = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [W-1:0]  wnib,
    output logic [W-1:0]  rnib
);
    logic [W-1:0]     cells [DEPTH];
    logic [DEPTH-1:0] live;

    // Storage array: written only while powered
    always_ff @(posedge clk) begin
        if (we && pwr_en) cells[addr] <= wnib;
    end

    // Live bits: cleared by reset and by power-down, set by a write
    always_ff @(posedge clk) begin
        if (!rst_n)      live <= '0;
        else if (!pwr_en) live <= '0;
        else if (we)      live[addr] <= 1'b1;
    end

    assign rnib = (pwr_en && live[addr]) ? cells[addr] : '0;
endmodule

// File: rtl/nsm_burst_ctrl.sv
// Module: nsm_burst_ctrl
// Accepts a read or write strobe while idle (write wins when both are high)
// and steps through the rows from the top row downward, one per cycle. It
// also holds the active word-length code. That code is reloaded only in
// cycles without an access, so it stays fixed for a whole burst. The strobe
// cycle itself is beat 0.
module nsm_burst_ctrl
    import nsm_pkg::*;
#(
    parameter int AW = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic [AW-1:0]    addr,
    input  wl_code_t         wl_sel,
    output wl_code_t         wl_q,
    output logic             act,
    output logic             cur_wr,
    output logic [ROW_W-1:0] cur_row,
    output logic [AW-1:0]    cur_addr,
    output logic             last_beat,
    output logic             busy
);
    logic             busy_q;
    logic [ROW_W-1:0] beat_q;
    logic [ROW_W-1:0] rows_q;
    logic             op_wr_q;
    logic [AW-1:0]    addr_q;
    logic             accept;
    logic [ROW_W-1:0] cur_beat;
    logic [ROW_W-1:0] cur_rows;

    // Current-beat view: taken from the strobe in beat 0, from latched state after that
    always_comb begin
        accept    = !busy_q && (rd_req || wr_req);
        act       = busy_q || accept;
        cur_beat  = busy_q ? beat_q : '0;
        cur_rows  = busy_q ? rows_q : ROW_W'(wl_q) + ROW_W'(MIN_ROWS);
        cur_wr    = busy_q ? op_wr_q : wr_req;
        cur_addr  = busy_q ? addr_q : addr;
        cur_row   = ROW_W'(ROWS - 1) - cur_beat;
        last_beat = act && (cur_beat == cur_rows - ROW_W'(1));
    end

    // Burst state and word-length register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            beat_q  <= '0;
            rows_q  <= '0;
            op_wr_q <= 1'b0;
            addr_q  <= '0;
            wl_q    <= 2'b11;
        end else begin
            busy_q <= act && !last_beat;
            beat_q <= (act && !last_beat) ? cur_beat + ROW_W'(1) : '0;
            if (accept) begin
                rows_q  <= cur_rows;
                op_wr_q <= wr_req;
                addr_q  <= addr;
            end
            if (!act) wl_q <= wl_sel;
        end
    end

    assign busy = busy_q;
endmodule

// File: rtl/nibble_sample_mem.sv
// Module: nibble_sample_mem (top)
// Sample memory for a radix-4 FFT engine, organised as a grid of nibble
// banks: ROWS slice rows by COLS operand columns. Each burst moves one
// butterfly's four operands, one row per cycle, starting at the top row.
// The active word-length sets how many rows take part and which rows stay
// powered. Assumes PTS is a multiple of 4.
module nibble_sample_mem
    import nsm_pkg::*;
#(
    parameter int PTS   = 64,
    localparam int DEPTH = PTS / 4,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       wl_sel,
    input  logic [AW-1:0]    addr,
    input  logic             rd_req,
    input  logic             wr_req,
    input  logic [BUS_W-1:0] wdata,
    output logic [BUS_W-1:0] rdata,
    output logic             rvalid,
    output logic             done,
    output logic [ROWS-1:0]  row_pwr_en
);
    wl_code_t         wl_q;
    logic             act;
    logic             cur_wr;
    logic [ROW_W-1:0] cur_row;
    logic [AW-1:0]    cur_addr;
    logic             last_beat;
    logic             busy;
    logic [BUS_W-1:0] row_bus [ROWS];
    logic [BUS_W-1:0] sel_bus;

    nsm_burst_ctrl #(.AW(AW)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_req    (rd_req),
        .wr_req    (wr_req),
        .addr      (addr),
        .wl_sel    (wl_sel),
        .wl_q      (wl_q),
        .act       (act),
        .cur_wr    (cur_wr),
        .cur_row   (cur_row),
        .cur_addr  (cur_addr),
        .last_beat (last_beat),
        .busy      (busy)
    );

    nsm_pwr_dec u_pwr (
        .wl_code (wl_q),
        .row_en  (row_pwr_en)
    );

    // Bank grid: one bank per (row, operand column)
    for (genvar r = 0; r < ROWS; r++) begin : g_r
        logic row_we;
        assign row_we = act && cur_wr && (cur_row == ROW_W'(r));
        for (genvar c = 0; c < COLS; c++) begin : g_c
            nsm_bank #(.DEPTH(DEPTH), .AW(AW), .W(NIB_W)) u_bank (
                .clk    (clk),
                .rst_n  (rst_n),
                .pwr_en (row_pwr_en[r]),
                .we     (row_we),
                .addr   (cur_addr),
                .wnib   (wdata[c*NIB_W +: NIB_W]),
                .rnib   (row_bus[r][c*NIB_W +: NIB_W])
            );
        end
    end

    // Row select: pick the bus word of the row being accessed
    always_comb begin
        sel_bus = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (cur_row == ROW_W'(r)) sel_bus = row_bus[r];
        end
    end

    // Output stage: read beat data, valid flag and end-of-burst pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            done   <= 1'b0;
        end else begin
            rdata  <= (act && !cur_wr) ? sel_bus : '0;
            rvalid <= act && !cur_wr;
            done   <= last_beat;
        end
    end
endmodule

// File: rtl/nsm_chk.sv
// Module: nsm_chk
// Property checker for nibble_sample_mem, attached by bind. It only
// observes ports and the burst-busy flag.
module nsm_chk
    import nsm_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             rd_req,
    input logic             wr_req,
    input logic             busy,
    input logic             rvalid,
    input logic             done,
    input logic [BUS_W-1:0] rdata,
    input logic [ROWS-1:0]  row_pwr_en
);
    logic [ROWS-1:0] pwr_off;
    assign pwr_off = ~row_pwr_en;

    AST_PWR_TOP_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ((pwr_off & (pwr_off + ROWS'(1))) == '0) && ($countones(row_pwr_en) >= MIN_ROWS)); // R9
    AST_PWR_HELD_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $stable(row_pwr_en)); // R8
    AST_RDATA_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !rvalid |-> (rdata == '0)); // R11
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6
    AST_READ_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && rd_req && !wr_req) |=> rvalid); // R5
    AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy)); // R2
endmodule

bind nibble_sample_mem nsm_chk u_nsm_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (rd_req),
    .wr_req     (wr_req),
    .busy       (busy),
    .rvalid     (rvalid),
    .done       (done),
    .rdata      (rdata),
    .row_pwr_en (row_pwr_en)
);

// File: tb/test_nibble_sample_mem.sv
module test_nibble_sample_mem;
    localparam int PTS = 64;
    localparam int AW  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  wl_sel = 2'd3;
    logic [AW-1:0] addr = '0;
    logic        rd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        rvalid;
    logic        done;
    logic [4:0]  row_pwr_en;

    int n_vec = 0;
    int n_bad = 0;

    // reference model state
    int m_mem [5][4][16];
    bit m_vld [5][4][16];
    int m_busy, m_beat, m_rows, m_wr, m_addr, m_wl;
    int e_rdata, e_rvalid, e_done, e_en;

    always #2 clk = ~clk;

    nibble_sample_mem #(.PTS(PTS)) i_nibble_sample_mem (
        .clk(clk), .rst_n(rst_n), .wl_sel(wl_sel), .addr(addr),
        .rd_req(rd_req), .wr_req(wr_req), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .done(done), .row_pwr_en(row_pwr_en)
    );

    function automatic int en_mask(int w);
        int m = 0;
        for (int r = 0; r < 5; r++) if (r >= 3 - w) m |= (1 << r);
        return m;
    endfunction

    task automatic check(string tag, int act_v, int exp_v);
        n_vec++;
        if (act_v != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
        end
    endtask

    // behavioural model of one clock edge
    task automatic model_edge();
        int act, beat, rows, wr, a, row;
        if (!rst_n) begin
            m_busy = 0; m_beat = 0; m_rows = 0; m_wr = 0; m_addr = 0; m_wl = 3;
            foreach (m_vld[r, c, k]) m_vld[r][c][k] = 0;
            e_rdata = 0; e_rvalid = 0; e_done = 0; e_en = en_mask(3);
            return;
        end
        act = (m_busy != 0) || rd_req || wr_req;
        e_rdata = 0; e_rvalid = 0; e_done = 0;
        if (act) begin
            beat = m_busy ? m_beat : 0;
            rows = m_busy ? m_rows : m_wl + 2;
            wr   = m_busy ? m_wr : int'(wr_req);
            a    = m_busy ? m_addr : int'(addr);
            row  = 4 - beat;
            if (!wr) begin
                e_rvalid = 1;
                for (int c = 0; c < 4; c++)
                    if (m_vld[row][c][a]) e_rdata |= (m_mem[row][c][a] << (4 * c));
            end else begin
                for (int c = 0; c < 4; c++) begin
                    m_mem[row][c][a] = (wdata >> (4 * c)) & 15;
                    m_vld[row][c][a] = 1;
                end
            end
            e_done = (beat == rows - 1);
            if (!m_busy) begin m_rows = rows; m_wr = wr; m_addr = a; end
            m_busy = !e_done;
            m_beat = e_done ? 0 : beat + 1;
        end
        for (int r = 0; r < 5; r++)
            if (!((en_mask(m_wl) >> r) & 1))
                for (int c = 0; c < 4; c++)
                    for (int k = 0; k < 16; k++) m_vld[r][c][k] = 0;
        if (!act) m_wl = wl_sel;
        e_en = en_mask(m_wl);
    endtask

    // one clock: model the edge, then compare the outputs 1 ns later
    task automatic step();
        @(posedge clk);
        model_edge();
        #1;
        check("R5 rvalid", rvalid, e_rvalid);
        check("R3 rdata", rdata, e_rdata);
        check("R6 done", done, e_done);
        check("R9 row_pwr_en", row_pwr_en, e_en);
    endtask

    function automatic int top_mask(int w);
        return 32'hFFFFF & ~((1 << ((3 - w) * 4)) - 1);
    endfunction

    task automatic set_wl(int w);
        wl_sel = 2'(w);
        step();
        check("R9 enables for word-length", row_pwr_en, en_mask(w));
    endtask

    task automatic do_write(int a, int wa, int wb, int wc, int wd, int beats, bit both);
        addr = AW'(a); wr_req = 1'b1; rd_req = both;
        for (int k = 0; k < beats; k++) begin
            int sh = (4 - k) * 4;
            wdata = {4'(wd >> sh), 4'(wc >> sh), 4'(wb >> sh), 4'(wa >> sh)};
            step();
            wr_req = 1'b0; rd_req = 1'b0;
            check("R7 no read beat on write", rvalid, 0);
        end
        wdata = '0;
    endtask

    task automatic do_read(int a, int beats, int new_wl, bit poke,
                           output int wa, output int wb, output int wc, output int wd);
        int en0;
        en0 = row_pwr_en;
        wa = 0; wb = 0; wc = 0; wd = 0;
        addr = AW'(a); rd_req = 1'b1;
        for (int k = 0; k < beats; k++) begin
            int sh = (4 - k) * 4;
            step();
            rd_req = 1'b0;
            if (k == 0 && new_wl >= 0) wl_sel = 2'(new_wl);
            if (poke && k == 1) begin wr_req = 1'b1; wdata = 16'hFFFF; end
            if (poke && k == 2) begin wr_req = 1'b0; wdata = '0; end
            check("R5 rvalid per beat", rvalid, 1);
            check("R6 done on last beat only", done, (k == beats - 1));
            check("R8 enables held in burst", row_pwr_en, en0);
            wa |= int'(rdata[3:0]) << sh;
            wb |= int'(rdata[7:4]) << sh;
            wc |= int'(rdata[11:8]) << sh;
            wd |= int'(rdata[15:12]) << sh;
        end
        wr_req = 1'b0; wdata = '0;
        step();
        check("R2 beat count", rvalid, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        int ra, rb, rc, rd;
        int va, vb, vc, vd;
        rst_n = 1'b0;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 rvalid", rvalid, 0);
        check("R1 done", done, 0);
        check("R1 rdata", rdata, 0);
        check("R1 row_pwr_en", row_pwr_en, 5'b11111);

        // R2 R4 R3: round trip at every word-length
        for (int w = 0; w < 4; w++) begin
            va = 20'h12345 ^ (w * 20'h11111); vb = 20'hABCDE; vc = 20'h0F0F0; vd = 20'h98765 ^ w;
            set_wl(w);
            do_write(w + 1, va, vb, vc, vd, w + 2, 1'b0);
            do_read(w + 1, w + 2, -1, 1'b0, ra, rb, rc, rd);
            check("R4 R3 operand A", ra, va & top_mask(w));
            check("R4 R3 operand B", rb, vb & top_mask(w));
            check("R4 R3 operand C", rc, vc & top_mask(w));
            check("R4 R3 operand D", rd, vd & top_mask(w));
        end

        // R10: content lost in powered-down rows
        set_wl(3);
        do_write(7, 20'hFEDCB, 20'h13579, 20'h2468A, 20'hC0FFE, 5, 1'b0);
        set_wl(0);
        set_wl(3);
        do_read(7, 5, -1, 1'b0, ra, rb, rc, rd);
        check("R10 operand A after power cycle", ra, 20'hFE000);
        check("R10 operand D after power cycle", rd, 20'hC0000);

        // R7: write strobe during a read burst is ignored
        do_write(9, 20'h11111, 20'h22222, 20'h33333, 20'h44444, 5, 1'b0);
        do_read(9, 5, -1, 1'b1, ra, rb, rc, rd);
        check("R7 read during poke", ra, 20'h11111);
        do_read(9, 5, -1, 1'b0, ra, rb, rc, rd);
        check("R7 memory unchanged A", ra, 20'h11111);
        check("R7 memory unchanged D", rd, 20'h44444);

        // R7: simultaneous strobes give a write
        do_write(3, 20'hAAAAA, 20'h55555, 20'h0, 20'hFFFFF, 5, 1'b1);
        do_read(3, 5, -1, 1'b0, ra, rb, rc, rd);
        check("R7 write wins A", ra, 20'hAAAAA);
        check("R7 write wins D", rd, 20'hFFFFF);

        // R8: word-length change mid-burst deferred
        do_read(9, 5, 0, 1'b0, ra, rb, rc, rd);
        check("R8 full burst despite change", rb, 20'h22222);
        check("R8 new enables after burst", row_pwr_en, 5'b11000);

        // R11: idle output zero
        repeat (2) step();
        check("R11 idle rdata", rdata, 0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule